// File: doc/BRIEF.md
# Phase-Table Weighted Round-Robin Port Arbiter

This block sits at a switch egress and decides which of several ingress ports may send in each clock cycle. Its schedule is a table of time slots, or phases. Each phase holds a 4-bit port number. A phase pointer steps through the table once per cycle. When the port named by the current phase is requesting, that port gets a one-cycle, one-hot grant. When it is not requesting, the slot goes unused.

Software programs the schedule over a 32-bit word register bus. It first writes a staged copy of the table, eight phases per word. It then writes a load command. For a fixed number of cycles the block reports that the load is busy. During that window arbitration keeps using the old active table, and the bus cannot change the staged copy. When the window ends, the staged copy replaces the active table in one cycle. A read-only capability word reports the table's location, the phase count and the entry width, so software can work out how many words to write. A 3-bit scheme field chooses between table-driven arbitration, plain round robin, and no grants at all.

Top module: `pwrr_port_arbiter`

## Requirements
- R1: After a synchronous reset the status word reads 0, the scheme field reads 0, the phase pointer is 0, and every phase of both the staged and the active table holds port 0.
- R2: Word address 0 reads a constant capability word. Bits [31:24] hold the table offset in 16-byte units (1, so the table starts at word address 4). Bits [3:0] flag the supported phase counts: bit0 means 32, bit1 means 64, bit2 means 128, bit3 means 256. The set bits are 0, 1 and 2, and the highest set bit wins, which gives 128. Bits [9:8] hold a code c, and the entry width is 1<<c (here 4). The number of table words equals entry width times phase count divided by 32, which is 16.
- R3: Table word k (word address 4+k) holds phases 8k to 8k+7. Phase 8k+j sits in bits [4j+3:4j]. Reading the word returns the staged value.
- R4: A write to word address 1 with bit0=1 while idle starts a load. The status word (address 2) reads 1 from the next cycle for exactly 16 cycles. The active table then equals the staged table.
- R5: While a load is busy, grants follow the previous active table.
- R6: While a load is busy, writes to table words and further load commands are ignored. A table write in the first idle cycle is accepted.
- R7: The scheme field is bits [19:17] of word address 1 and reads back there. Value 3 selects table arbitration, value 0 selects plain round robin, and any other value gives no grants.
- R8: The phase pointer advances by one every cycle, whatever the scheme, and wraps from 127 to 0.
- R9: Under scheme 3, if the current phase names port p and req[p] is high, then gnt equals the one-hot code for p in that same cycle. Otherwise gnt is 0, and this includes entries of 4 or more.
- R10: Under scheme 0, gnt is the first requesting port after the last round-robin grantee, searching circularly. The last grantee resets to port 3.
- R11: With every table word set to 0x21111111 and loaded, phases 7, 15, ..., 127 grant port 2 and all other phases grant port 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 4 | Request, one bit per ingress port |
| gnt | output | 4 | One-hot grant, valid in the cycle it is shown |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |

## Verification
Two things can fall in the same clock edge: the end of a load, which swaps the active table, and the bus access to the staged table. The bench provokes this by writing one table word in the last busy cycle and another in the first idle cycle. It then reads both back: the first write must have no effect and the second must stick. Arbitration lookup can also coincide with the swap. For this, requests are held steady across the whole load, and each cycle's grant is compared with a reference model. That model switches tables only after its own count of 16 busy cycles.

// File: rtl/pwrr_pkg.sv
package pwrr_pkg;
  localparam int NPORTS  = 4;
  localparam int PHASES  = 128;
  localparam int ENTRY_W = 4;
  localparam int TBL_OFF = 1;   // table offset, 16-byte units
  localparam int ADDR_W  = 8;   // word address width
  localparam int SEL_W   = 3;
  localparam int SEL_LSB = 17;

  localparam logic [SEL_W-1:0] SCH_RR  = 3'd0;
  localparam logic [SEL_W-1:0] SCH_TBL = 3'd3;

  // capability word: [31:24] offset, [9:8] log2 entry width, [3:0] phase support
  function automatic logic [31:0] cap_word();
    logic [31:0] c;
    c = '0;
    for (int i = 0; i < 4; i++)
      if ((32 << i) <= PHASES) c[i] = 1'b1;
    c[9:8]   = 2'($clog2(ENTRY_W));
    c[31:24] = 8'(TBL_OFF);
    return c;
  endfunction

  function automatic int cap_phases(logic [31:0] c);
    if (c[3])      return 256;
    else if (c[2]) return 128;
    else if (c[1]) return 64;
    else if (c[0]) return 32;
    return 0;
  endfunction

  function automatic int cap_entry_w(logic [31:0] c);
    return 1 << c[9:8];
  endfunction

  function automatic int cap_dwords(logic [31:0] c);
    return cap_entry_w(c) * cap_phases(c) / 32;
  endfunction

  localparam logic [31:0] CAP = cap_word();
  localparam int NUM_DW   = cap_dwords(CAP);
  localparam int IDX_W    = $clog2(NUM_DW);
  localparam int PH_W     = $clog2(PHASES);
  localparam int EPD      = 32 / ENTRY_W;
  localparam int EPD_W    = $clog2(EPD);
  localparam int PORT_W   = $clog2(NPORTS);
  localparam int TBL_BASE = TBL_OFF * 4;

  // first requester strictly after 'last', circular
  function automatic logic [NPORTS-1:0] rr_pick(logic [NPORTS-1:0] r, logic [PORT_W-1:0] last);
    logic [NPORTS-1:0] g;
    int idx;
    g = '0;
    for (int k = 1; k <= NPORTS; k++) begin
      idx = (int'(last) + k) % NPORTS;
      if (g == '0 && r[idx]) g[idx] = 1'b1;
    end
    return g;
  endfunction

  function automatic logic [PORT_W-1:0] oh_index(logic [NPORTS-1:0] oh);
    logic [PORT_W-1:0] n;
    n = '0;
    for (int i = 0; i < NPORTS; i++)
      if (oh[i]) n = PORT_W'(i);
    return n;
  endfunction
endpackage

// File: rtl/pwrr_regs.sv
module pwrr_regs
  import pwrr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reg_wr,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  output logic [SEL_W-1:0]            sel,
  output logic [NUM_DW-1:0][31:0]     active
);
  localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_TB   = ADDR_W'(TBL_BASE);
  localparam logic [ADDR_W-1:0] A_TE   = ADDR_W'(TBL_BASE + NUM_DW);

  logic [NUM_DW-1:0][31:0] staged;
  logic                    busy;
  logic [IDX_W-1:0]        cnt;

  // named events for the checks below
  logic             ctrl_wr, load_go, load_done, tbl_hit, tbl_wr;
  logic [IDX_W-1:0] tbl_idx;
  logic [ADDR_W-1:0] tbl_off;

  assign ctrl_wr   = reg_wr && (reg_addr == A_CTRL);
  assign load_go   = ctrl_wr && reg_wdata[0] && !busy;
  assign load_done = busy && (cnt == IDX_W'(NUM_DW - 1));
  assign tbl_hit   = (reg_addr >= A_TB) && (reg_addr < A_TE);
  assign tbl_wr    = reg_wr && tbl_hit;
  assign tbl_off   = reg_addr - A_TB;
  assign tbl_idx   = tbl_off[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel    <= '0;
      busy   <= 1'b0;
      cnt    <= '0;
      staged <= '0;
      active <= '0;
    end else begin
      if (ctrl_wr) sel <= reg_wdata[SEL_LSB +: SEL_W];
      if (tbl_wr && !busy) staged[tbl_idx] <= reg_wdata;
      if (load_go) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (load_done) begin
        busy   <= 1'b0;
        active <= staged;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CAP)       reg_rdata = CAP;
    else if (reg_addr == A_CTRL) reg_rdata = 32'(sel) << SEL_LSB;
    else if (reg_addr == A_STAT) reg_rdata = {31'b0, busy};
    else if (tbl_hit)            reg_rdata = staged[tbl_idx];
  end

  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst) load_go |=> busy);
  // R6
  staged_hold_chk: assert property (@(posedge clk) disable iff (rst) (tbl_wr && busy) |=> $stable(staged));
  // R5
  active_hold_chk: assert property (@(posedge clk) disable iff (rst) !load_done |=> $stable(active));
endmodule

// File: rtl/pwrr_sched.sv
module pwrr_sched
  import pwrr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPORTS-1:0]       req,
  input  logic [SEL_W-1:0]        sel,
  input  logic [NUM_DW-1:0][31:0] active,
  output logic [NPORTS-1:0]       gnt
);
  logic [PH_W-1:0]    ptr;
  logic [31:0]        cur_word;
  logic [ENTRY_W-1:0] cur_ent;
  logic [NPORTS-1:0]  tbl_gnt, rr_gnt;
  logic [PORT_W-1:0]  last;

  assign cur_word = active[ptr[PH_W-1:EPD_W]];
  assign cur_ent  = ENTRY_W'(cur_word >> (int'(ptr[EPD_W-1:0]) * ENTRY_W));

  for (genvar p = 0; p < NPORTS; p++) begin : g_slot
    assign tbl_gnt[p] = req[p] && (cur_ent == ENTRY_W'(p));
  end

  assign rr_gnt = rr_pick(req, last);

  always_comb begin
    if (sel == SCH_TBL)     gnt = tbl_gnt;
    else if (sel == SCH_RR) gnt = rr_gnt;
    else                    gnt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      last <= PORT_W'(NPORTS - 1);
    end else begin
      ptr <= (ptr == PH_W'(PHASES - 1)) ? '0 : ptr + 1'b1;
      if (sel == SCH_RR && rr_gnt != '0) last <= oh_index(rr_gnt);
    end
  end

  // R9
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
  // R9
  gnt_req_chk: assert property (@(posedge clk) disable iff (rst) (gnt & ~req) == '0);
  // R8
  phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr == PH_W'(PHASES - 1)) |=> (ptr == '0));
endmodule

// File: rtl/pwrr_port_arbiter.sv
module pwrr_port_arbiter
  import pwrr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NPORTS-1:0]   req,
  output logic [NPORTS-1:0]   gnt,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata
);
  logic [SEL_W-1:0]        sel;
  logic [NUM_DW-1:0][31:0] active;

  pwrr_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .sel       (sel),
    .active    (active)
  );

  pwrr_sched u_sched (
    .clk    (clk),
    .rst    (rst),
    .req    (req),
    .sel    (sel),
    .active (active),
    .gnt    (gnt)
  );
endmodule

// File: tb/test_pwrr_port_arbiter.sv
`timescale 1ns/100ps
module test_pwrr_port_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  req = '0;
  logic [3:0]  gnt;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  always #2.5 clk = ~clk;

  pwrr_port_arbiter i_pwrr_port_arbiter (
    .clk(clk), .rst(rst), .req(req), .gnt(gnt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  typedef struct {
    logic [3:0]  g;
    bit          crd;
    logic [31:0] rd;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [31:0] m_active [16];
  logic [31:0] m_staged [16];
  int          m_rem = 0;
  int          m_sel = 0;
  int          m_ptr = 0;
  int          m_last = 3;
  logic [31:0] last_rd;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic [7:0] a);
    if (a == 0) return 32'h0100_0207;
    if (a == 1) return 32'(m_sel) << 17;
    if (a == 2) return (m_rem > 0) ? 32'd1 : 32'd0;
    if (a >= 4 && a < 20) return m_staged[a - 4];
    return 32'd0;
  endfunction

  task automatic tick(logic [3:0] r, bit w, logic [7:0] a, logic [31:0] d, bit crd, string tag);
    item_t it;
    int ent;
    bit was_busy;
    req = r; reg_wr = w; reg_addr = a; reg_wdata = d;
    it.g = '0;
    if (m_sel == 3) begin
      ent = int'((m_active[m_ptr / 8] >> ((m_ptr % 8) * 4)) & 32'hF);
      if (ent < 4 && r[ent]) it.g[ent] = 1'b1;
    end else if (m_sel == 0) begin
      for (int k = 1; k <= 4; k++) begin
        int idx;
        idx = (m_last + k) % 4;
        if (it.g == '0 && r[idx]) begin
          it.g[idx] = 1'b1;
          m_last = idx;
        end
      end
    end
    it.crd = crd;
    it.rd  = model_read(a);
    it.tag = tag;
    q.push_back(it);
    // state after the coming edge
    m_ptr = (m_ptr + 1) % 128;
    was_busy = (m_rem > 0);
    if (was_busy) begin
      m_rem--;
      if (m_rem == 0) for (int i = 0; i < 16; i++) m_active[i] = m_staged[i];
    end
    if (w) begin
      if (a == 1) begin
        m_sel = int'(d[19:17]);
        if (d[0] && !was_busy) m_rem = 16;
      end
      if (a >= 4 && a < 20 && !was_busy) m_staged[a - 4] = d;
    end
    #1 last_rd = reg_rdata;
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(gnt == it.g, {it.tag, " gnt"}, 32'(gnt), 32'(it.g));
        if (it.crd) chk(reg_rdata == it.rd, {it.tag, " rdata"}, reg_rdata, it.rd);
      end
    end
  end

  // watchdog
  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic int dec_phases(logic [31:0] c);
    for (int b = 3; b >= 0; b--) if (c[b]) return 32 << b;
    return 0;
  endfunction

  initial begin
    int ph, ew;
    for (int i = 0; i < 16; i++) begin m_active[i] = '0; m_staged[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    reg_addr = 8'd2; #1;
    chk(reg_rdata == 32'd0, "R1 status after reset", reg_rdata, 32'd0);
    chk(gnt == 4'd0, "R1 gnt in reset", 32'(gnt), 32'd0);
    reg_addr = 8'd1; #1;
    chk(reg_rdata == 32'd0, "R1 scheme after reset", reg_rdata, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R2 capability
    tick(4'b0000, 0, 8'd0, 32'd0, 1, "R2 cap word");
    ph = dec_phases(last_rd);
    ew = 1 << last_rd[9:8];
    chk(ph == 128, "R2 phase count", 32'(ph), 32'd128);
    chk(ew == 4, "R2 entry width", 32'(ew), 32'd4);
    chk(ew * ph / 32 == 16, "R2 dword count", 32'(ew * ph / 32), 32'd16);
    chk(last_rd[31:24] * 4 == 4, "R2 table word base", 32'(last_rd[31:24] * 4), 32'd4);

    // R7 scheme readback, R1 active table all port 0
    tick(4'b0000, 1, 8'd1, 32'h0006_0000, 0, "R7 scheme write");
    tick(4'b0000, 0, 8'd1, 32'd0, 1, "R7 scheme read");
    repeat (4) tick(4'b0001, 0, 8'd2, 32'd0, 1, "R1 table maps port0");
    repeat (3) tick(4'b1110, 0, 8'd2, 32'd0, 1, "R1 other ports idle");

    // R3 fill and read back
    for (int k = 0; k < 16; k++) tick(4'b0000, 1, 8'(4 + k), 32'h2111_1111, 0, "R3 fill");
    tick(4'b0000, 0, 8'd4, 32'd0, 1, "R3 readback first");
    tick(4'b0000, 0, 8'd19, 32'd0, 1, "R3 readback last");

    // R4 load, R5 old table used while busy
    tick(4'b0111, 1, 8'd1, 32'h0006_0001, 0, "R4 load command");
    repeat (18) tick(4'b0111, 0, 8'd2, 32'd0, 1, "R4 R5 busy window");

    // R11 pattern over a wrap (R8)
    repeat (140) tick(4'b0110, 0, 8'd2, 32'd0, 1, "R11 R8 pattern and wrap");
    repeat (20) tick(4'b0010, 0, 8'd2, 32'd0, 1, "R9 missing requester skipped");

    // R6 ignore while busy
    tick(4'b0000, 1, 8'd1, 32'h0006_0001, 0, "R4 second load");
    tick(4'b0000, 1, 8'd4, 32'h3333_3333, 0, "R6 write while busy");
    tick(4'b0000, 1, 8'd1, 32'h0006_0001, 0, "R6 load while busy");
    repeat (13) tick(4'b0110, 0, 8'd2, 32'd0, 1, "R6 busy status");
    tick(4'b0000, 1, 8'd9, 32'h4444_4444, 0, "R6 write last busy cycle");
    tick(4'b0000, 1, 8'd10, 32'h0000_0001, 0, "R6 write first idle cycle");
    tick(4'b0000, 0, 8'd4, 32'd0, 1, "R6 readback word0");
    tick(4'b0000, 0, 8'd9, 32'd0, 1, "R6 readback word5");
    tick(4'b0000, 0, 8'd10, 32'd0, 1, "R6 readback word6");
    tick(4'b0000, 0, 8'd2, 32'd0, 1, "R6 idle status");

    // R9 entries: out-of-range ports never granted
    tick(4'b0000, 1, 8'd4, 32'h0000_0003, 0, "R9 write word0");
    tick(4'b0000, 1, 8'd5, 32'h0000_00F5, 0, "R9 write word1");
    tick(4'b0000, 1, 8'd1, 32'h0006_0001, 0, "R9 load");
    repeat (20) tick(4'b1111, 0, 8'd2, 32'd0, 1, "R9 R5 during load");
    repeat (140) tick(4'b1111, 0, 8'd2, 32'd0, 1, "R9 entry decode");

    // R10 plain round robin
    tick(4'b0000, 1, 8'd1, 32'h0000_0000, 0, "R10 select rr");
    repeat (6) tick(4'b1011, 0, 8'd1, 32'd0, 1, "R10 rr 1011");
    repeat (3) tick(4'b0100, 0, 8'd1, 32'd0, 1, "R10 rr 0100");
    repeat (5) tick(4'b1001, 0, 8'd1, 32'd0, 1, "R10 rr 1001");
    repeat (2) tick(4'b0000, 0, 8'd1, 32'd0, 1, "R10 rr none");

    // R7 unsupported scheme
    tick(4'b0000, 1, 8'd1, 32'h000A_0000, 0, "R7 select 5");
    repeat (5) tick(4'b1111, 0, 8'd1, 32'd0, 1, "R7 no grant scheme 5");

    reg_wr = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule